// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block produces the four gate-drive enables for an isolated half-bridge converter with synchronous rectification on the secondary side. A free-running period counter sets a fixed switching frequency. The two primary switches, low side and high side, take turns on successive oscillator cycles, so each one switches at half the oscillator rate. Two secondary rectifier enables are shaped around the primary pulses. The rectifier tied to the active primary switch is released first and retaken afterwards, each by its own programmable guard delay. Outside those windows both rectifiers conduct together to let the output freewheel.

A start attempt begins when `enable` is high and `uv_fault` is low. The block first waits a programmable number of silent oscillator cycles. It then starts switching, always with a low-side pulse. The on-time grows from a programmable minimum by a fixed step each cycle until it reaches the commanded value. The duty command is inverted: zero asks for the largest pulse and full scale for the smallest. A fault or a dropped enable clears all four outputs at once and restarts the whole sequence.

Top module: `hb_gate_seq`

## Requirements
- R1: Primary pulses alternate low side, high side, low side, and so on. The rising edge of a high-side pulse comes exactly `period` clocks after the rising edge of the low-side pulse before it.
- R2: The first primary pulse after every start attempt is on `pri_lo`. A start attempt follows reset, a rise of `enable`, or a clear of `uv_fault`.
- R3: After a start attempt, both secondary outputs rise and stay high, with no primary pulse, for exactly `idle_cycles` times `period` clocks (a value of 0 acts as 1). Then switching begins.
- R4: Pulse k after a start attempt (k counted from 0) has an on-time of min(`min_on` + k*`ss_step`, commanded on-time) clocks.
- R5: While `uv_fault` is high or `enable` is low, all four outputs are 0 in the same cycle, with no clock edge needed. The next start attempt repeats the idle period and restarts the ramp at `min_on`.
- R6: A primary output rises only after its related secondary output has been low for at least `dt_pri` clocks. `pri_lo` is related to `sec_lo` and `pri_hi` to `sec_hi`.
- R7: A secondary output rises again only after its related primary output has been low for at least `dt_sec` clocks.
- R8: A primary output and its related secondary output are never high together, and both secondary outputs are never high while a primary output is high. Both secondary outputs are high during the idle period.
- R9: The commanded on-time is L - floor(`duty_cmd`*L / 2^DUTY_W), where L = `period` - `dt_pri` - `dt_sec` - 1 (0 if negative). So `duty_cmd` = 0 gives L.
- R10: No pulse lasts longer than L clocks, even when the soft-start limit has grown past L.
- R11: `duty_cmd` is sampled once, at the start of each oscillator cycle. A change during a pulse leaves that pulse's width unchanged and applies from the next cycle.
- R12: `pri_lo` and `pri_hi` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| enable | input | 1 | Run request; low acts as shutdown |
| uv_fault | input | 1 | Under-voltage or shutdown flag; high forces all drives off |
| period | input | CNT_W | Oscillator period in clocks |
| idle_cycles | input | IDLE_W | Silent oscillator cycles before first pulse |
| min_on | input | CNT_W | Soft-start starting on-time in clocks |
| ss_step | input | CNT_W | Soft-start on-time increase per cycle in clocks |
| dt_pri | input | DT_W | Guard from secondary off to primary on, clocks |
| dt_sec | input | DT_W | Guard from primary off to secondary on, clocks |
| duty_cmd | input | DUTY_W | Inverted duty command |
| pri_lo | output | 1 | Primary low-side drive enable |
| pri_hi | output | 1 | Primary high-side drive enable |
| sec_lo | output | 1 | Secondary rectifier enable related to the low side |
| sec_hi | output | 1 | Secondary rectifier enable related to the high side |

## Verification
The hardest situation to reach from the ports is a change that lands in the middle of a live pulse. One case is a duty command change while a primary output is high. The other is a fault that strikes partway through a low-side pulse and must cut it short, then restart from an idle period with the first pulse on the low side. The stimulus waits at a falling clock edge until the low-side output is seen high and makes the change there. It then follows the widths and sides of the pulses that come after. A monitor runs the whole time and measures every guard interval between each primary output and its related rectifier against the programmed value.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_IDLE = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_e;

   localparam int NUM_LEGS = 2;
   localparam int LEG_LO   = 0;
   localparam int LEG_HI   = 1;
endpackage

// File: rtl/hbs_period_ctr.sv
module hbs_period_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam int EW = CNT_W + 1;

   // last clock of an oscillator cycle; a period of 0 or 1 wraps every clock
   assign wrap = count_en && ((EW'(cnt) + EW'(1)) >= EW'(period));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!count_en || wrap)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/hbs_ontime.sv
module hbs_ontime #(
   parameter int CNT_W  = 16,
   parameter int DUTY_W = 8,
   parameter int DT_W   = 8
) (
   input  logic [CNT_W-1:0]  period,
   input  logic [DT_W-1:0]   dt_a,
   input  logic [DT_W-1:0]   dt_b,
   input  logic [DUTY_W-1:0] duty_cmd,
   input  logic [CNT_W-1:0]  ss_lim,
   output logic [CNT_W-1:0]  t_on
);
   localparam int EW = CNT_W + 1;
   localparam int PW = CNT_W + DUTY_W;

   logic [EW-1:0]    overhead;
   logic [CNT_W-1:0] lim;
   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] cut;
   logic [CNT_W-1:0] cmd_on;

   always_comb begin
      overhead = EW'(dt_a) + EW'(dt_b) + EW'(1);
      lim      = (EW'(period) > overhead) ? CNT_W'(EW'(period) - overhead) : '0;
      prod     = PW'(duty_cmd) * PW'(lim);
      cut      = CNT_W'(prod >> DUTY_W);
      cmd_on   = lim - cut;
      t_on     = (ss_lim < cmd_on) ? ss_lim : cmd_on;
   end
endmodule

// File: rtl/hbs_leg.sv
module hbs_leg #(
   parameter int CNT_W = 16,
   parameter int DT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shut,
   input  logic             active,
   input  logic             freewheel,
   input  logic [CNT_W-1:0] cnt,
   input  logic [DT_W-1:0]  dt_a,
   input  logic [DT_W-1:0]  dt_b,
   input  logic [CNT_W-1:0] t_on,
   output logic             pri,
   output logic             sec
);
   localparam int EW = CNT_W + 2;

   logic [EW-1:0] on_start, on_end, sr_end, pos;
   logic          pri_d, sec_d, pri_q, sec_q;

   always_comb begin
      pos      = EW'(cnt);
      on_start = EW'(dt_a);
      on_end   = on_start + EW'(t_on);
      sr_end   = on_end + EW'(dt_b);
      pri_d    = active && (pos >= on_start) && (pos < on_end);
      sec_d    = freewheel && !(active && (pos < sr_end));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || shut) begin
         pri_q <= 1'b0;
         sec_q <= 1'b0;
      end else begin
         pri_q <= pri_d;
         sec_q <= sec_d;
      end
   end

   // shutdown takes effect without waiting for an edge
   assign pri = pri_q & ~shut;
   assign sec = sec_q & ~shut;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
   import hbs_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DUTY_W = 8,
   parameter int DT_W   = 8,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              uv_fault,
   input  logic [CNT_W-1:0]  period,
   input  logic [IDLE_W-1:0] idle_cycles,
   input  logic [CNT_W-1:0]  min_on,
   input  logic [CNT_W-1:0]  ss_step,
   input  logic [DT_W-1:0]   dt_pri,
   input  logic [DT_W-1:0]   dt_sec,
   input  logic [DUTY_W-1:0] duty_cmd,
   output logic              pri_lo,
   output logic              pri_hi,
   output logic              sec_lo,
   output logic              sec_hi
);
   localparam int IEW = IDLE_W + 1;
   localparam int SEW = CNT_W + 1;

   if (CNT_W < DT_W + 2) begin : g_bad_cnt
      initial $fatal(1, "hb_gate_seq: CNT_W must exceed DT_W by at least 2");
   end
   if (DUTY_W < 2) begin : g_bad_duty
      initial $fatal(1, "hb_gate_seq: DUTY_W must be at least 2");
   end
   if (IDLE_W < 1) begin : g_bad_idle
      initial $fatal(1, "hb_gate_seq: IDLE_W must be at least 1");
   end

   seq_state_e        state_q;
   logic [IDLE_W-1:0] idle_cnt;
   logic [CNT_W-1:0]  ss_q, ss_sat, ss_use, t_next, t_q;
   logic [SEW-1:0]    ss_sum;
   logic              side_q, pulse_q, shut, wrap, idle_last;
   logic [CNT_W-1:0]  cnt;
   logic [NUM_LEGS-1:0] pri_v, sec_v;

   assign shut = uv_fault | ~enable;

   hbs_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en ((state_q != ST_OFF) && !shut),
      .period   (period),
      .cnt      (cnt),
      .wrap     (wrap)
   );

   always_comb begin
      ss_sum    = SEW'(ss_q) + SEW'(ss_step);
      ss_sat    = ss_sum[CNT_W] ? '1 : ss_sum[CNT_W-1:0];
      ss_use    = (state_q == ST_RUN) ? ss_sat : ss_q;
      idle_last = (IEW'(idle_cnt) + IEW'(1)) >= IEW'(idle_cycles);
   end

   hbs_ontime #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W)) u_ontime (
      .period   (period),
      .dt_a     (dt_pri),
      .dt_b     (dt_sec),
      .duty_cmd (duty_cmd),
      .ss_lim   (ss_use),
      .t_on     (t_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || shut) begin
         state_q  <= ST_OFF;
         idle_cnt <= '0;
         ss_q     <= '0;
         t_q      <= '0;
         side_q   <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_q  <= ST_IDLE;
               idle_cnt <= '0;
               ss_q     <= min_on;
               side_q   <= 1'b0;
               pulse_q  <= 1'b0;
            end
            ST_IDLE: begin
               if (wrap) begin
                  if (idle_last) begin
                     state_q <= ST_RUN;
                     t_q     <= t_next;
                     pulse_q <= (t_next != '0);
                     side_q  <= 1'b0;
                  end else begin
                     idle_cnt <= idle_cnt + IDLE_W'(1);
                  end
               end
            end
            ST_RUN: begin
               if (wrap) begin
                  ss_q    <= ss_sat;
                  t_q     <= t_next;
                  pulse_q <= (t_next != '0);
                  side_q  <= pulse_q ? ~side_q : side_q;
               end
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      hbs_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
         .clk       (clk),
         .rst_n     (rst_n),
         .shut      (shut),
         .active    ((state_q == ST_RUN) && pulse_q && (side_q == 1'(g))),
         .freewheel ((state_q == ST_IDLE) || (state_q == ST_RUN)),
         .cnt       (cnt),
         .dt_a      (dt_pri),
         .dt_b      (dt_sec),
         .t_on      (t_q),
         .pri       (pri_v[g]),
         .sec       (sec_v[g])
      );
   end

   assign pri_lo = pri_v[LEG_LO];
   assign pri_hi = pri_v[LEG_HI];
   assign sec_lo = sec_v[LEG_LO];
   assign sec_hi = sec_v[LEG_HI];
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int DT_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable,
   input logic            uv_fault,
   input logic [DT_W-1:0] dt_pri,
   input logic [DT_W-1:0] dt_sec,
   input logic            pri_lo,
   input logic            pri_hi,
   input logic            sec_lo,
   input logic            sec_hi
);
   logic lo_seen;

   always_ff @(posedge clk) begin
      if (!rst_n || uv_fault || !enable)
         lo_seen <= 1'b0;
      else if (pri_lo)
         lo_seen <= 1'b1;
   end

   a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_lo && pri_hi));

   a_r8_lo_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      pri_lo |-> !sec_lo);

   a_r8_hi_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      pri_hi |-> !sec_hi);

   a_r5_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_fault || !enable) |-> !(pri_lo || pri_hi || sec_lo || sec_hi));

   a_r2_lo_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_hi) |-> lo_seen);

   a_r6_lo_guard: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_pri != '0) && $rose(pri_lo)) |-> !$past(sec_lo));

   a_r6_hi_guard: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_pri != '0) && $rose(pri_hi)) |-> !$past(sec_hi));

   a_r7_lo_guard: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_sec != '0) && $rose(sec_lo)) |-> !$past(pri_lo));

   a_r7_hi_guard: assert property (@(posedge clk) disable iff (!rst_n)
      ((dt_sec != '0) && $rose(sec_hi)) |-> !$past(pri_hi));
endmodule

bind hb_gate_seq hbs_checker #(.DT_W(DT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .uv_fault (uv_fault),
   .dt_pri   (dt_pri),
   .dt_sec   (dt_sec),
   .pri_lo   (pri_lo),
   .pri_hi   (pri_hi),
   .sec_lo   (sec_lo),
   .sec_hi   (sec_hi)
);

// File: tb/hb_gate_seq_tb.sv
`timescale 1ns/1ps
module hb_gate_seq_tb;
   localparam int CNT_W = 16, DUTY_W = 8, DT_W = 8, IDLE_W = 8;

   typedef struct packed {
      int p; int dtp; int dts; int duty; int exp_on;
   } vec_t;

   // expected on-time = L - floor(duty*L/256), L = p - dtp - dts - 1
   localparam vec_t VECS [4] = '{
      '{p: 100, dtp: 5,  dts: 7,  duty: 0,   exp_on: 87},
      '{p: 100, dtp: 5,  dts: 7,  duty: 128, exp_on: 44},
      '{p: 60,  dtp: 3,  dts: 2,  duty: 255, exp_on: 1},
      '{p: 200, dtp: 10, dts: 10, duty: 64,  exp_on: 135}
   };

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, uv_fault = 1'b0;
   logic [CNT_W-1:0]  period = 16'd50, min_on = 16'd1, ss_step = 16'd255;
   logic [IDLE_W-1:0] idle_cycles = 8'd1;
   logic [DT_W-1:0]   dt_pri = 8'd4, dt_sec = 8'd4;
   logic [DUTY_W-1:0] duty_cmd = '0;
   logic pri_lo, pri_hi, sec_lo, sec_hi;

   always #5 clk = ~clk;

   hb_gate_seq #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W), .IDLE_W(IDLE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .uv_fault(uv_fault),
      .period(period), .idle_cycles(idle_cycles), .min_on(min_on), .ss_step(ss_step),
      .dt_pri(dt_pri), .dt_sec(dt_sec), .duty_cmd(duty_cmd),
      .pri_lo(pri_lo), .pri_hi(pri_hi), .sec_lo(sec_lo), .sec_hi(sec_hi)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   int cyc = 0, run_w = 0, npulse = 0, idle_hi = 0, p_meas = 0;
   int lo_rise_t = 0, sl_fall_t = 0, sh_fall_t = 0, pl_fall_t = 0, ph_fall_t = 0;
   int w [16];
   bit sd [16];
   bit sl_fell = 0, lo_done = 0, hi_done = 0;
   int ov_bad = 0, both_bad = 0, g6_bad = 0, g7_bad = 0, g6_n = 0, g7_n = 0;
   logic pl_d = 0, ph_d = 0, sl_d = 0, sh_d = 0;

   always @(negedge clk) begin
      cyc++;
      if (pri_lo && pri_hi) ov_bad++;
      if ((pri_lo || pri_hi) && sec_lo && sec_hi) both_bad++;
      if (!rst_n || uv_fault || !enable) begin
         npulse = 0; idle_hi = 0; sl_fell = 0; lo_done = 0; hi_done = 0;
      end else begin
         if (sec_lo && !sl_fell) idle_hi++;
         if (!sec_lo && sl_d) begin sl_fell = 1; sl_fall_t = cyc; end
         if (!sec_hi && sh_d) sh_fall_t = cyc;
         if (pri_lo && !pl_d) begin
            lo_rise_t = cyc; run_w = 0; g6_n++;
            if (cyc - sl_fall_t < int'(dt_pri)) g6_bad++;
         end
         if (pri_hi && !ph_d) begin
            p_meas = cyc - lo_rise_t; run_w = 0; g6_n++;
            if (cyc - sh_fall_t < int'(dt_pri)) g6_bad++;
         end
         if (pri_lo || pri_hi) run_w++;
         if ((!pri_lo && pl_d) || (!pri_hi && ph_d)) begin
            if (npulse < 16) begin w[npulse] = run_w; sd[npulse] = ph_d; end
            if (pl_d) begin pl_fall_t = cyc; lo_done = 1; end
            else      begin ph_fall_t = cyc; hi_done = 1; end
            npulse++;
         end
         if (sec_lo && !sl_d && lo_done) begin
            g7_n++;
            if (cyc - pl_fall_t < int'(dt_sec)) g7_bad++;
         end
         if (sec_hi && !sh_d && hi_done) begin
            g7_n++;
            if (cyc - ph_fall_t < int'(dt_sec)) g7_bad++;
         end
      end
      pl_d = pri_lo; ph_d = pri_hi; sl_d = sec_lo; sh_d = sec_hi;
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wait_pulses(int n);
      while (npulse < n) tick(1);
   endtask

   task automatic wait_lo_high();
      while (!pri_lo) tick(1);
   endtask

   task automatic restart(int p, int dtp, int dts, int duty, int mo, int st, int idl);
      tick(1); enable = 1'b0; tick(3);
      period = CNT_W'(p); dt_pri = DT_W'(dtp); dt_sec = DT_W'(dts);
      duty_cmd = DUTY_W'(duty); min_on = CNT_W'(mo); ss_step = CNT_W'(st);
      idle_cycles = IDLE_W'(idl);
      tick(1); enable = 1'b1;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      while (cyc < 150000 && !done) @(negedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      tick(4);
      chk("R5 reset outputs low", {28'd0, pri_lo, pri_hi, sec_lo, sec_hi}, 0);
      rst_n = 1'b1;
      tick(2);
      chk("R5 disabled outputs low", {28'd0, pri_lo, pri_hi, sec_lo, sec_hi}, 0);

      // idle period: 3 cycles of 50 clocks
      restart(50, 4, 4, 0, 1, 255, 3);
      tick(20);
      chk("R8 both rectifiers on in idle", {30'd0, sec_lo, sec_hi}, 3);
      chk("R3 no primary pulse in idle", {30'd0, pri_lo, pri_hi}, 0);
      wait_pulses(1);
      chk("R3 idle length in clocks", idle_hi, 150);
      chk("R2 first pulse on low side", int'(sd[0]), 0);

      // table of steady-state on-times
      foreach (VECS[i]) begin
         restart(VECS[i].p, VECS[i].dtp, VECS[i].dts, VECS[i].duty, 1, 255, 1);
         wait_pulses(5);
         chk("R9 high-side on-time", w[3], VECS[i].exp_on);
         chk("R9 low-side on-time", w[4], VECS[i].exp_on);
         chk("R1 pulse 3 on high side", int'(sd[3]), 1);
         chk("R1 low-to-high rise spacing", p_meas, VECS[i].p);
      end

      // soft-start ramp: 10, 30, 50, 70, then capped at 87
      restart(100, 5, 7, 0, 10, 20, 1);
      wait_pulses(5);
      chk("R4 ramp pulse 0", w[0], 10);
      chk("R4 ramp pulse 1", w[1], 30);
      chk("R4 ramp pulse 2", w[2], 50);
      chk("R10 ramp capped at limit", w[4], 87);
      chk("R1 ramp pulse 1 on high side", int'(sd[1]), 1);

      // duty change inside a live pulse
      begin
         int k;
         wait_lo_high();
         k = npulse;
         duty_cmd = 8'd255;
         wait_pulses(k + 2);
         chk("R11 pulse in flight keeps width", w[k], 87);
         chk("R11 next pulse uses new command", w[k+1], 1);
      end

      // fault in the middle of a low-side pulse
      duty_cmd = 8'd0;
      wait_pulses(npulse + 2);
      wait_lo_high();
      uv_fault = 1'b1;
      #1;
      chk("R5 fault clears outputs at once", {28'd0, pri_lo, pri_hi, sec_lo, sec_hi}, 0);
      tick(5);
      chk("R5 outputs held low in fault", {28'd0, pri_lo, pri_hi, sec_lo, sec_hi}, 0);
      uv_fault = 1'b0;
      wait_pulses(2);
      chk("R2 first pulse after fault on low side", int'(sd[0]), 0);
      chk("R5 ramp restarts at min_on", w[0], 10);
      chk("R4 ramp step after restart", w[1], 30);

      chk("R12 primary overlap samples", ov_bad, 0);
      chk("R8 rectifiers both on during pulse", both_bad, 0);
      chk("R6 guard violations", g6_bad, 0);
      chk("R7 guard violations", g7_bad, 0);
      chk("R6 guard intervals measured", int'(g6_n > 20), 1);
      chk("R7 guard intervals measured", int'(g7_n > 20), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule